// File: doc/BRIEF.md
# Dual-Priority Send Command Queue

This block is the host-facing command front end of a network transmit engine. Software starts a transmission on a virtual channel by doing one bus write. The write address picks the priority class. For a user process it also picks the channel, so a process can only start sends on a channel whose page it can reach. The data word gives the start and stop word offsets inside that channel's double-page buffer.

Channel zero belongs to the kernel. A write whose address names channel zero takes the real channel number from a field of the data word, so the kernel can drive every channel through one page. Accepted commands go into a high-priority queue or a low-priority queue. The cell-transmit engine always sees the head of the high queue before anything in the low queue. The engine is expected to look at the presented command again at every cell boundary, so a long low-priority send gives way to an urgent message.

A queue that is full does not stall the bus. The command is simply discarded. Each channel keeps a small status word that software reads to learn whether its commands were accepted.

The bus write decode is an operation enumeration: `OP_NONE`, `OP_PUSH_LO`, `OP_PUSH_HI`, `OP_STATUS`.

The consumer-side selector is an enumeration with three values:
- `PICK_NONE`: both queues are empty.
- `PICK_HI`: the high queue is not empty.
- `PICK_LO`: only the low queue holds entries.

The selector has no stored state; it is chosen again every cycle.

The status read path is a two-state machine:
- `RSP_IDLE` moves to `RSP_VALID` on a status read.
- `RSP_VALID` stays in `RSP_VALID` on a back-to-back read.
- `RSP_VALID` returns to `RSP_IDLE` otherwise.

Top module: `snd_cmd_frontend`

## Requirements
- R1: The address is {region[1:0], channel[7:0]}. With `host_we` high, region 00 pushes to the low queue and region 01 pushes to the high queue. With `host_re` high, region 10 reads status. Region 11, and any access with the other strobe, has no effect.
- R2: The command data word holds the start offset in bits [11:0] and the stop offset in bits [23:12]. For a nonzero address channel, the queued channel is the address channel.
- R3: When the address channel is 0, the queued channel is taken from data bits [31:24].
- R4: While the high queue holds any entry, the presented command comes from it and `cmd_hi` is 1. Otherwise the low queue head is presented with `cmd_hi` 0.
- R5: Within each queue, commands are presented in the order they were accepted.
- R6: Each queue holds 8 commands. A push to a full queue without a same-cycle pop is discarded and leaves the queue contents unchanged.
- R7: A discarded command sets that channel's rejected flag (status bit 0). The flag stays set until a status read of that channel. A status read returns `host_rvalid` and data one cycle after the request, showing the value from before the read.
- R8: An accepted command sets its channel's pending flag (status bit 1). Popping a presented command clears the pending flag of that command's channel, unless a new command for that channel is accepted in the same cycle.
- R9: A push to a full queue in the same cycle as a pop from that queue is accepted.
- R10: After reset both queues are empty, `cmd_valid` is 0, and every status word reads 0.
- R11: `cmd_pop` while `cmd_valid` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_addr | input | 10 | Region and channel address |
| host_wdata | input | 32 | Command data word |
| host_rvalid | output | 1 | Status read data valid |
| host_rdata | output | 32 | Status word, pending bit 1, rejected bit 0 |
| cmd_valid | output | 1 | A command is presented |
| cmd_hi | output | 1 | Presented command is high priority |
| cmd_ch | output | 8 | Presented channel |
| cmd_start | output | 12 | Presented start offset |
| cmd_stop | output | 12 | Presented stop offset |
| cmd_pop | input | 1 | Engine takes the presented command |

## Verification
The hardest case to reach from the ports is a push and a pop landing on the same edge against a queue that is exactly full. Only that case separates correct acceptance from a silent drop. The bench fills the low queue with eight writes. It then drives the ninth write and `cmd_pop` in one cycle, drains the queue, and checks that the ninth command arrives last with no rejected flag raised. A separate overflow scenario shows the opposite outcome, and then reads the status word twice to show that the rejected flag clears only on a read.

// File: rtl/snd_cmd_pkg.sv
package snd_cmd_pkg;
    typedef enum logic [1:0] {OP_NONE, OP_PUSH_LO, OP_PUSH_HI, OP_STATUS} host_op_e;
    typedef enum logic [1:0] {PICK_NONE, PICK_HI, PICK_LO} pick_e;
    typedef enum logic {RSP_IDLE, RSP_VALID} rsp_e;
endpackage

// File: rtl/snd_cmd_fifo.sv
module snd_cmd_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         accept
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;
    logic          full, pop_eff;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign pop_eff = pop && !empty;
    // a full queue still takes a write when its head leaves in the same cycle
    assign accept  = push && (!full || pop_eff);
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (accept)  wr_ptr <= wr_ptr + 1'b1;
            if (pop_eff) rd_ptr <= rd_ptr + 1'b1;
            unique case ({accept, pop_eff})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R6
    AST_FULL_DROP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> ($stable(count) && $stable(wr_ptr))); // R6
    AST_PUSH_POP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && pop) |=> (count == CW'(DEPTH))); // R9
endmodule

// File: rtl/snd_cmd_status.sv
module snd_cmd_status #(
    parameter int CH_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_pend,
    input  logic [CH_W-1:0] set_ch,
    input  logic            clr_pend,
    input  logic [CH_W-1:0] clr_ch,
    input  logic            set_rej,
    input  logic            rd,
    input  logic [CH_W-1:0] rd_ch,
    output logic            rd_pend,
    output logic            rd_rej
);
    localparam int NCH = 1 << CH_W;

    logic [NCH-1:0] pend_q, rej_q;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q[i] <= 1'b0;
                rej_q[i]  <= 1'b0;
            end else begin
                if (set_pend && set_ch == CH_W'(i))      pend_q[i] <= 1'b1;
                else if (clr_pend && clr_ch == CH_W'(i)) pend_q[i] <= 1'b0;
                // a rejection on the same edge as the read survives the read
                if (set_rej && set_ch == CH_W'(i))       rej_q[i]  <= 1'b1;
                else if (rd && rd_ch == CH_W'(i))        rej_q[i]  <= 1'b0;
            end
        end
    end

    assign rd_pend = pend_q[rd_ch];
    assign rd_rej  = rej_q[rd_ch];

    AST_REJ_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
        set_rej |=> rej_q[$past(set_ch)]); // R7
    AST_PEND_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
        set_pend |=> pend_q[$past(set_ch)]); // R8
endmodule

// File: rtl/snd_cmd_frontend.sv
module snd_cmd_frontend
    import snd_cmd_pkg::*;
#(
    parameter int CH_W   = 8,
    parameter int OFF_W  = 12,
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_we,
    input  logic                host_re,
    input  logic [CH_W+1:0]     host_addr,
    input  logic [DATA_W-1:0]   host_wdata,
    output logic                host_rvalid,
    output logic [DATA_W-1:0]   host_rdata,
    output logic                cmd_valid,
    output logic                cmd_hi,
    output logic [CH_W-1:0]     cmd_ch,
    output logic [OFF_W-1:0]    cmd_start,
    output logic [OFF_W-1:0]    cmd_stop,
    input  logic                cmd_pop
);
    localparam int ENT_W  = CH_W + 2 * OFF_W;
    localparam int KCH_LO = 2 * OFF_W;
    localparam int NQ     = 2;   // index 0 low priority, 1 high priority

    host_op_e        op;
    pick_e           pick;
    rsp_e            rsp_state;
    logic [1:0]      region;
    logic [CH_W-1:0] addr_ch, wr_ch;
    logic [ENT_W-1:0] wr_ent;
    logic [NQ-1:0]   q_push, q_pop, q_empty, q_acc;
    logic [ENT_W-1:0] q_dout [NQ];
    logic [ENT_W-1:0] head;
    logic            any_push, any_acc;
    logic            st_pend, st_rej;
    logic [1:0]      rsp_bits;

    assign region  = host_addr[CH_W+1:CH_W];
    assign addr_ch = host_addr[CH_W-1:0];

    always_comb begin
        op = OP_NONE;
        unique case (region)
            2'b00:   if (host_we) op = OP_PUSH_LO;
            2'b01:   if (host_we) op = OP_PUSH_HI;
            2'b10:   if (host_re) op = OP_STATUS;
            default: op = OP_NONE;
        endcase
    end

    // channel zero is the kernel's window onto every channel
    assign wr_ch  = (addr_ch == '0) ? host_wdata[KCH_LO +: CH_W] : addr_ch;
    assign wr_ent = {wr_ch, host_wdata[OFF_W +: OFF_W], host_wdata[0 +: OFF_W]};

    assign q_push[0] = (op == OP_PUSH_LO);
    assign q_push[1] = (op == OP_PUSH_HI);
    assign q_pop[0]  = cmd_pop && (pick == PICK_LO);
    assign q_pop[1]  = cmd_pop && (pick == PICK_HI);

    for (genvar q = 0; q < NQ; q++) begin : g_q
        snd_cmd_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
            .clk    (clk),
            .rst_n  (rst_n),
            .push   (q_push[q]),
            .pop    (q_pop[q]),
            .din    (wr_ent),
            .dout   (q_dout[q]),
            .empty  (q_empty[q]),
            .accept (q_acc[q])
        );
    end

    always_comb begin
        pick = PICK_NONE;
        head = q_dout[0];
        unique case ({q_empty[1], q_empty[0]})
            2'b00, 2'b01: begin pick = PICK_HI; head = q_dout[1]; end
            2'b10:        begin pick = PICK_LO; head = q_dout[0]; end
            default:      begin pick = PICK_NONE; head = q_dout[0]; end
        endcase
    end

    assign cmd_valid = (pick != PICK_NONE);
    assign cmd_hi    = (pick == PICK_HI);
    assign cmd_ch    = head[2*OFF_W +: CH_W];
    assign cmd_stop  = head[OFF_W +: OFF_W];
    assign cmd_start = head[0 +: OFF_W];

    assign any_push = |q_push;
    assign any_acc  = |q_acc;

    snd_cmd_status #(.CH_W(CH_W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_pend (any_acc),
        .set_ch   (wr_ch),
        .clr_pend (cmd_pop && cmd_valid),
        .clr_ch   (cmd_ch),
        .set_rej  (any_push && !any_acc),
        .rd       (op == OP_STATUS),
        .rd_ch    (addr_ch),
        .rd_pend  (st_pend),
        .rd_rej   (st_rej)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_state <= RSP_IDLE;
            rsp_bits  <= 2'b00;
        end else begin
            unique case (rsp_state)
                RSP_IDLE:  if (op == OP_STATUS) rsp_state <= RSP_VALID;
                RSP_VALID: if (op != OP_STATUS) rsp_state <= RSP_IDLE;
                default:   rsp_state <= RSP_IDLE;
            endcase
            if (op == OP_STATUS) rsp_bits <= {st_pend, st_rej};
        end
    end

    always_comb begin
        host_rvalid = (rsp_state == RSP_VALID);
        host_rdata  = '0;
        if (rsp_state == RSP_VALID) host_rdata[1:0] = rsp_bits;
    end

    AST_HIGH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        !q_empty[1] |-> (cmd_valid && cmd_hi)); // R4
    AST_STATUS_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_re && !host_we && region == 2'b10) |=> host_rvalid); // R7
    AST_IDLE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !host_re |=> !host_rvalid); // R1
endmodule

// File: tb/tb_snd_cmd_frontend.sv
module tb_snd_cmd_frontend;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_we, host_re, cmd_pop;
    logic [9:0]  host_addr;
    logic [31:0] host_wdata;
    logic        host_rvalid, cmd_valid, cmd_hi;
    logic [31:0] host_rdata;
    logic [7:0]  cmd_ch;
    logic [11:0] cmd_start, cmd_stop;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    snd_cmd_frontend dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rvalid(host_rvalid), .host_rdata(host_rdata),
        .cmd_valid(cmd_valid), .cmd_hi(cmd_hi), .cmd_ch(cmd_ch),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_pop(cmd_pop)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one bus write; outputs are sampled on the following falling edge
    task automatic wr(logic [1:0] reg_, logic [7:0] ch, logic [7:0] kch,
                      logic [11:0] st, logic [11:0] sp, logic pop_too);
        @(negedge clk);
        host_we    = 1'b1;
        host_addr  = {reg_, ch};
        host_wdata = {kch, sp, st};
        cmd_pop    = pop_too;
        @(negedge clk);
        host_we = 1'b0;
        cmd_pop = 1'b0;
    endtask

    task automatic pop1();
        @(negedge clk);
        cmd_pop = 1'b1;
        @(negedge clk);
        cmd_pop = 1'b0;
    endtask

    task automatic rd_status(logic [7:0] ch, string req, int exp);
        @(negedge clk);
        host_re   = 1'b1;
        host_addr = {2'b10, ch};
        @(negedge clk);
        host_re = 1'b0;
        check({req, " rvalid"}, int'(host_rvalid), 1);
        check({req, " status"}, int'(host_rdata), exp);
    endtask

    task automatic t_reset();
        check("R10 valid after reset", int'(cmd_valid), 0);
        check("R10 rvalid after reset", int'(host_rvalid), 0);
        rd_status(8'h05, "R10", 0);
    endtask

    task automatic t_user();
        wr(2'b00, 8'h12, 8'hAA, 12'h100, 12'h1FF, 1'b0);
        check("R1 valid", int'(cmd_valid), 1);
        check("R1 low class", int'(cmd_hi), 0);
        check("R2 channel from address", int'(cmd_ch), 'h12);
        check("R2 start", int'(cmd_start), 'h100);
        check("R2 stop", int'(cmd_stop), 'h1FF);
        rd_status(8'h12, "R8 pending set", 2);
        pop1();
        check("R8 drained", int'(cmd_valid), 0);
        rd_status(8'h12, "R8 pending cleared", 0);
    endtask

    task automatic t_kernel();
        wr(2'b01, 8'h00, 8'h77, 12'h020, 12'h3C0, 1'b0);
        check("R3 valid", int'(cmd_valid), 1);
        check("R3 channel from data", int'(cmd_ch), 'h77);
        check("R1 high class", int'(cmd_hi), 1);
        pop1();
        check("R3 drained", int'(cmd_valid), 0);
    endtask

    task automatic t_priority();
        wr(2'b00, 8'h21, 8'h0, 12'h001, 12'h00F, 1'b0);
        wr(2'b00, 8'h22, 8'h0, 12'h002, 12'h00F, 1'b0);
        wr(2'b01, 8'h23, 8'h0, 12'h003, 12'h00F, 1'b0);
        check("R4 high presented", int'(cmd_ch), 'h23);
        check("R4 cmd_hi", int'(cmd_hi), 1);
        pop1();
        check("R5 first low", int'(cmd_ch), 'h21);
        check("R4 low class", int'(cmd_hi), 0);
        pop1();
        check("R5 second low", int'(cmd_ch), 'h22);
        pop1();
        check("R5 empty", int'(cmd_valid), 0);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 9; i++) wr(2'b00, 8'h03, 8'h0, 12'(i), 12'hFFF, 1'b0);
        rd_status(8'h03, "R7 rejected and pending", 3);
        rd_status(8'h03, "R7 rejected cleared by read", 2);
        for (int i = 0; i < 8; i++) begin
            check("R6 kept entry", int'(cmd_start), i);
            pop1();
        end
        check("R6 dropped entry absent", int'(cmd_valid), 0);
    endtask

    task automatic t_simul();
        for (int i = 0; i < 8; i++) wr(2'b00, 8'h44, 8'h0, 12'(16 + i), 12'h0, 1'b0);
        wr(2'b00, 8'h44, 8'h0, 12'h0AB, 12'h0, 1'b1);
        for (int i = 1; i < 8; i++) begin
            check("R9 order", int'(cmd_start), 16 + i);
            pop1();
        end
        check("R9 accepted", int'(cmd_start), 'h0AB);
        pop1();
        check("R9 drained", int'(cmd_valid), 0);
        rd_status(8'h44, "R9 no rejection", 0);
    endtask

    task automatic t_ignored();
        wr(2'b11, 8'h50, 8'h0, 12'h111, 12'h222, 1'b0);
        check("R1 region 11 ignored", int'(cmd_valid), 0);
        @(negedge clk);
        host_re   = 1'b1;
        host_addr = {2'b00, 8'h50};
        @(negedge clk);
        host_re = 1'b0;
        check("R1 read of queue region", int'(host_rvalid), 0);
        rd_status(8'h50, "R1 no status change", 0);
    endtask

    task automatic t_pop_empty();
        pop1();
        pop1();
        check("R11 still empty", int'(cmd_valid), 0);
        wr(2'b00, 8'h60, 8'h0, 12'h060, 12'h061, 1'b0);
        check("R11 entry", int'(cmd_ch), 'h60);
        pop1();
        check("R11 empty after one pop", int'(cmd_valid), 0);
    endtask

    initial begin
        host_we = 0; host_re = 0; cmd_pop = 0; host_addr = '0; host_wdata = '0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_user();
        t_kernel();
        t_priority();
        t_overflow();
        t_simul();
        t_ignored();
        t_pop_empty();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule